// File: doc/BRIEF.md
# Byte-Addressed NVRAM with BCD Time-of-Day Registers

This block models a battery-backed byte memory whose topmost eight locations form a calendar clock window. A host reaches it over a single-cycle synchronous byte bus: an address, a write strobe with write data, and a read strobe whose result appears on the read data output one clock later. Every location outside the window behaves as plain RAM. The window holds a control byte and seven BCD time fields: seconds, minutes, hours, day of week with a century flag, date, month and a two-digit year.

A one-cycle-wide tick input, pulsed once per second, advances the calendar with full carry from seconds up to the year, including month lengths and a leap-year rule. A stop flag kept in the top bit of the seconds register freezes the count. Time-field writes are range-checked per field; a value out of range, or with a BCD digit above nine, leaves that field untouched. The bus address is wider than the memory and is truncated to `ADDR_W` bits, so the space repeats. An 8 KiB part uses `ADDR_W = 13`; the default is 2 KiB to keep elaboration light, and the window always sits at the top eight addresses of whatever space is chosen.

Top module: `nvram_bcd_clock`

## Requirements
- R1: Only the low `ADDR_W` bits of `addr` select a location; any two bus addresses that agree in those bits reach the same byte, inside or outside the clock window.
- R2: A write to an address below the window stores `wdata`; a read strobe in cycle N puts the addressed byte on `rdata` after the clock edge ending cycle N, and `rdata` then holds until the next read strobe. A read in the same cycle as a write to the same place returns the old value.
- R3: A write to the control location (window offset 0) stores `(wdata & 8'h5F) | 8'h90`, so bit 7 and bit 4 read as 1 and bit 5 as 0; a read returns the stored byte unchanged.
- R4: Reset sets the time to 00:00:00, day of week 1, date 01, month 01, year 00, stop flag and century flag 0, and `rdata` to 0; RAM contents survive reset.
- R5: Each tick while not stopped advances seconds 00 to 59 in BCD; 59 wraps to 00 and carries into minutes (59 to 00), then hours (23 to 00); the hour wrap advances day of week (7 to 1, otherwise plus one) and the date.
- R6: The date wraps to 01 after the last day of the month (30 for months 04, 06, 09, 11; 28 for month 02, or 29 when the year is a multiple of four; 31 otherwise), carrying into the month; month 12 wraps to 01 and carries into the year, which wraps 99 to 00.
- R7: Bit 7 of a seconds write (window offset 1) sets or clears the stop flag whatever the low bits hold; while it is set ticks have no effect, and after it is cleared counting resumes from the frozen time. Bit 7 of a seconds read returns the flag.
- R8: Seconds and minutes (offsets 1 and 2) take the low 7 bits of `wdata`, accepted only for BCD 00 to 59; hours (offset 3) take the low 6 bits, accepted only for 00 to 23. A rejected value leaves the field unchanged.
- R9: A write to offset 4 always loads the day of week from bits 2:0 and the century flag from bit 6; a read returns the century flag in bit 6 and the day of week in bits 2:0, other bits 0.
- R10: Date (offset 5) takes the low 6 bits, accepted for BCD 01 to 31; month (offset 6) takes the low 5 bits, accepted for 01 to 12; year (offset 7) takes all 8 bits, accepted for 00 to 99. A BCD digit above nine rejects the write.
- R11: When a tick and a time-field write land in the same cycle, the written field takes the written value (if accepted) and every other field advances as the tick dictates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the clock state and read register |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | BUS_AW | Byte address, truncated to ADDR_W bits |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
A corrupted time field is not visible until the host reads it, so the bench reads fields right after each carry boundary and compares every cycle against a behavioural calendar; a wrong carry shows within one read, one cycle after the strobe. A bad month-length or leap decision surfaces only on the single tick that crosses a month end, which is why those crossings are set up directly by writes. A stop flag that leaks ticks, or a rejected write that slips into a field, shows as a changed seconds or field value on the next read.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    localparam int BYTE_W = 8;
    localparam int WIN_AW = 3;

    typedef enum logic [WIN_AW-1:0] {
        FLD_CTRL = 3'd0,
        FLD_SEC  = 3'd1,
        FLD_MIN  = 3'd2,
        FLD_HOUR = 3'd3,
        FLD_WDAY = 3'd4,
        FLD_DATE = 3'd5,
        FLD_MON  = 3'd6,
        FLD_YEAR = 3'd7
    } fld_e;

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_t;

    localparam rtc_t RTC_RESET = '{
        halt: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
        cent: 1'b0, wday: 3'd1, date: 6'h01, mon: 5'h01, year: 8'h00
    };

    localparam logic [7:0] CTRL_CLR = 8'hA0;
    localparam logic [7:0] CTRL_SET = 8'h90;

    function automatic logic bcd_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic bcd_in(input logic [7:0] v,
                                    input logic [7:0] lo,
                                    input logic [7:0] hi);
        return bcd_ok(v) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10 = 2 (mod 4): year mod 4 = 2*tens[0] + ones (mod 4)
    function automatic logic leap_year(input logic [7:0] y);
        logic [3:0] s;
        s = {2'b00, y[4], 1'b0} + y[3:0];
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] last_day(input logic [4:0] mon,
                                            input logic [7:0] y);
        case (mon)
            5'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/nvc_ram.sv
module nvc_ram
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wd,
    output logic [BYTE_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // contents are never reset: they model battery-backed storage
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wd;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (rd_en)
            q <= mem[addr];
    end
endmodule

// File: rtl/nvc_clock.sv
module nvc_clock
    import nvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr,
    input  fld_e              fld,
    input  logic [BYTE_W-1:0] wd,
    output rtc_t              tm_q
);
    rtc_t       adv;
    rtc_t       nxt;
    logic       c_sec, c_min, c_hour, c_date, c_mon, c_year;
    logic [7:0] inc_sec, inc_min, inc_hour, inc_date, inc_mon, inc_year;
    logic [7:0] w_sec, w_hour, w_date, w_mon;

    // carry chain for one tick
    always_comb begin
        c_sec  = tick && !tm_q.halt;
        c_min  = c_sec  && (tm_q.sec  == 7'h59);
        c_hour = c_min  && (tm_q.min  == 7'h59);
        c_date = c_hour && (tm_q.hour == 6'h23);
        c_mon  = c_date && ({2'b00, tm_q.date} >= last_day(tm_q.mon, tm_q.year));
        c_year = c_mon  && (tm_q.mon  == 5'h12);

        inc_sec  = bcd_inc({1'b0, tm_q.sec});
        inc_min  = bcd_inc({1'b0, tm_q.min});
        inc_hour = bcd_inc({2'b00, tm_q.hour});
        inc_date = bcd_inc({2'b00, tm_q.date});
        inc_mon  = bcd_inc({3'b000, tm_q.mon});
        inc_year = bcd_inc(tm_q.year);

        adv = tm_q;
        if (c_sec)
            adv.sec = c_min ? 7'h00 : inc_sec[6:0];
        if (c_min)
            adv.min = c_hour ? 7'h00 : inc_min[6:0];
        if (c_hour)
            adv.hour = c_date ? 6'h00 : inc_hour[5:0];
        if (c_date) begin
            adv.wday = (tm_q.wday == 3'd7) ? 3'd1 : tm_q.wday + 3'd1;
            adv.date = c_mon ? 6'h01 : inc_date[5:0];
        end
        if (c_mon)
            adv.mon = c_year ? 5'h01 : inc_mon[4:0];
        if (c_year)
            adv.year = (tm_q.year == 8'h99) ? 8'h00 : inc_year;
    end

    // a host write overrides only the field it addresses
    always_comb begin
        w_sec  = {1'b0, wd[6:0]};
        w_hour = {2'b00, wd[5:0]};
        w_date = {2'b00, wd[5:0]};
        w_mon  = {3'b000, wd[4:0]};
        nxt    = adv;
        if (wr) begin
            case (fld)
                FLD_SEC: begin
                    nxt.halt = wd[7];
                    if (bcd_in(w_sec, 8'h00, 8'h59))
                        nxt.sec = wd[6:0];
                end
                FLD_MIN: begin
                    if (bcd_in(w_sec, 8'h00, 8'h59))
                        nxt.min = wd[6:0];
                end
                FLD_HOUR: begin
                    if (bcd_in(w_hour, 8'h00, 8'h23))
                        nxt.hour = wd[5:0];
                end
                FLD_WDAY: begin
                    nxt.wday = wd[2:0];
                    nxt.cent = wd[6];
                end
                FLD_DATE: begin
                    if (bcd_in(w_date, 8'h01, 8'h31))
                        nxt.date = wd[5:0];
                end
                FLD_MON: begin
                    if (bcd_in(w_mon, 8'h01, 8'h12))
                        nxt.mon = wd[4:0];
                end
                FLD_YEAR: begin
                    if (bcd_in(wd, 8'h00, 8'h99))
                        nxt.year = wd;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tm_q <= RTC_RESET;
        else
            tm_q <= nxt;
    end
endmodule

// File: rtl/nvc_window.sv
module nvc_window
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wd,
    input  rtc_t              tm,
    output logic              ram_we,
    output logic              clk_wr,
    output fld_e              fld,
    output logic              sel_q,
    output logic [BYTE_W-1:0] win_q,
    output logic [BYTE_W-1:0] ctrl_q
);
    logic              in_win;
    logic [BYTE_W-1:0] win_byte;

    assign in_win = &addr[ADDR_W-1:WIN_AW];
    assign fld    = fld_e'(addr[WIN_AW-1:0]);
    assign ram_we = we && !in_win;
    assign clk_wr = we && in_win && (fld != FLD_CTRL);

    // control byte sits with the RAM contents: not reset
    always_ff @(posedge clk) begin
        if (we && in_win && (fld == FLD_CTRL))
            ctrl_q <= (wd & ~CTRL_CLR) | CTRL_SET;
    end

    always_comb begin
        case (fld)
            FLD_CTRL: win_byte = ctrl_q;
            FLD_SEC:  win_byte = {tm.halt, tm.sec};
            FLD_MIN:  win_byte = {1'b0, tm.min};
            FLD_HOUR: win_byte = {2'b00, tm.hour};
            FLD_WDAY: win_byte = {1'b0, tm.cent, 3'b000, tm.wday};
            FLD_DATE: win_byte = {2'b00, tm.date};
            FLD_MON:  win_byte = {3'b000, tm.mon};
            FLD_YEAR: win_byte = tm.year;
            default:  win_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            win_q <= '0;
        end else if (rd_en) begin
            sel_q <= in_win;
            win_q <= win_byte;
        end
    end
endmodule

// File: rtl/nvram_bcd_clock.sv
module nvram_bcd_clock
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BUS_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_m;
    logic              unused_hi;
    logic              ram_we;
    logic              clk_wr;
    fld_e              fld;
    logic              sel_q;
    logic [BYTE_W-1:0] win_q;
    logic [BYTE_W-1:0] ram_q;
    logic [BYTE_W-1:0] ctrl_q;
    rtc_t              tm_q;

    // upper bus bits alias the space
    assign addr_m    = addr[ADDR_W-1:0];
    assign unused_hi = ^addr[BUS_AW-1:ADDR_W];

    nvc_window #(.ADDR_W(ADDR_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr_m),
        .we     (we),
        .rd_en  (rd_en),
        .wd     (wdata),
        .tm     (tm_q),
        .ram_we (ram_we),
        .clk_wr (clk_wr),
        .fld    (fld),
        .sel_q  (sel_q),
        .win_q  (win_q),
        .ctrl_q (ctrl_q)
    );

    nvc_clock u_clk (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wr   (clk_wr),
        .fld  (fld),
        .wd   (wdata),
        .tm_q (tm_q)
    );

    nvc_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .rd_en (rd_en),
        .addr  (addr_m),
        .wd    (wdata),
        .q     (ram_q)
    );

    assign rdata = sel_q ? win_q : ram_q;
endmodule

// File: rtl/nvram_bcd_clock_chk.sv
module nvram_bcd_clock_chk
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rdata,
    input rtc_t              tm,
    input logic [BYTE_W-1:0] ctrl
);
    logic win_any, ctrl_wr, time_wr;

    assign win_any = &addr[ADDR_W-1:WIN_AW];
    assign ctrl_wr = we && win_any && (addr[WIN_AW-1:0] == 3'd0);
    assign time_wr = we && win_any && (addr[WIN_AW-1:0] != 3'd0);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));                                   // R2
    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl[7] && ctrl[4] && !ctrl[5]));                 // R3
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tm.sec <= 7'h59) && (tm.sec[3:0] <= 4'd9));                   // R5
    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tm.hour <= 6'h23) && (tm.hour[3:0] <= 4'd9));                 // R8
    AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (tm.date != 6'h00) && (tm.date <= 6'h31));                     // R6
    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tm.mon >= 5'h01) && (tm.mon <= 5'h12));                       // R10
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (tm.halt && !time_wr) |=> $stable(tm));                        // R7
endmodule

bind nvram_bcd_clock nvram_bcd_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr_m),
    .we    (we),
    .rd_en (rd_en),
    .rdata (rdata),
    .tm    (tm_q),
    .ctrl  (ctrl_q)
);

// File: tb/nvram_bcd_clock_tb.sv
module nvram_bcd_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 11;
    localparam int WIN  = 'h7F8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_stop, m_cent;
    int m_ctrl;
    int mem_m [int];
    int exp_rdata;

    nvram_bcd_clock #(.ADDR_W(AW), .BUS_AW(16)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr),
        .wdata(wdata), .we(we), .rd_en(rd_en), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction
    function automatic bit bcd_good(int v);
        return (((v >> 4) & 15) <= 9) && ((v & 15) <= 9);
    endfunction
    function automatic int from_bcd(int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction
    function automatic int month_len(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1;
        m_mon = 1; m_year = 0; m_stop = 0; m_cent = 0;
        exp_rdata = 0;
    endtask

    function automatic int model_read(int a);
        int am = a & ((1 << AW) - 1);
        if (am < WIN) return mem_m.exists(am) ? mem_m[am] : 0;
        case (am - WIN)
            0: return m_ctrl;
            1: return (m_stop << 7) | to_bcd(m_sec);
            2: return to_bcd(m_min);
            3: return to_bcd(m_hour);
            4: return (m_cent << 6) | m_dow;
            5: return to_bcd(m_date);
            6: return to_bcd(m_mon);
            default: return to_bcd(m_year);
        endcase
    endfunction

    task automatic model_tick();
        if (m_stop) return;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    if (m_date >= month_len(m_mon, m_year)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year = (m_year + 1) % 100;
                        end
                    end else m_date++;
                end
            end
        end
    endtask

    task automatic model_write(int a, int d);
        int am = a & ((1 << AW) - 1);
        int v;
        if (am < WIN) begin mem_m[am] = d; return; end
        case (am - WIN)
            0: m_ctrl = (d & 'h5F) | 'h90;
            1: begin
                v = d & 'h7F;
                if (bcd_good(v) && from_bcd(v) <= 59) m_sec = from_bcd(v);
                m_stop = (d >> 7) & 1;
            end
            2: begin
                v = d & 'h7F;
                if (bcd_good(v) && from_bcd(v) <= 59) m_min = from_bcd(v);
            end
            3: begin
                v = d & 'h3F;
                if (bcd_good(v) && from_bcd(v) <= 23) m_hour = from_bcd(v);
            end
            4: begin m_dow = d & 7; m_cent = (d >> 6) & 1; end
            5: begin
                v = d & 'h3F;
                if (bcd_good(v) && from_bcd(v) >= 1 && from_bcd(v) <= 31) m_date = from_bcd(v);
            end
            6: begin
                v = d & 'h1F;
                if (bcd_good(v) && from_bcd(v) >= 1 && from_bcd(v) <= 12) m_mon = from_bcd(v);
            end
            default: begin
                if (bcd_good(d)) m_year = from_bcd(d);
            end
        endcase
    endtask

    task automatic check(string tag);
        checks++;
        if (rdata !== exp_rdata[7:0]) begin
            failures++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", tag, rdata, exp_rdata[7:0], $time);
        end
    endtask

    // one bus cycle, compared against the model on every clock
    task automatic step(bit w, bit r, int a, int d, bit t, string tag);
        @(negedge clk);
        we = w; rd_en = r; addr = a[15:0]; wdata = d[7:0]; tick = t;
        if (r) exp_rdata = model_read(a);
        if (t) model_tick();
        if (w) model_write(a, d);
        @(posedge clk); #1;
        check(tag);
    endtask

    task automatic wr(int a, int d, string tag);  step(1, 0, a, d, 0, tag); endtask
    task automatic rd(int a, string tag);         step(0, 1, a, 0, 0, tag); endtask
    task automatic tk(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, tag);
    endtask
    task automatic rd_all(string tag);
        for (int i = 1; i < 8; i++) rd(WIN + i, tag);
    endtask
    task automatic set_time(int yr, int mo, int dt, int hr, int mi, int se, string tag);
        wr(WIN + 7, yr, tag); wr(WIN + 6, mo, tag); wr(WIN + 5, dt, tag);
        wr(WIN + 3, hr, tag); wr(WIN + 2, mi, tag); wr(WIN + 1, se, tag);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst = 1; we = 0; rd_en = 0; tick = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        model_reset();
        #1; check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_ctrl = 0;
        model_reset();
        do_reset("R4 reset rdata");
        rd_all("R4 reset time");

        // R2 plain RAM, read-before-write ordering and hold
        wr('h0123, 'hA5, "R2 write");
        wr('h0000, 'h3C, "R2 write");
        wr(WIN - 1, 'h77, "R2 write top ram");
        rd('h0123, "R2 read");
        step(0, 0, 0, 0, 0, "R2 hold");
        step(0, 0, 0, 0, 0, "R2 hold");
        rd(WIN - 1, "R2 read top ram");
        step(1, 1, 'h0000, 'h4B, 0, "R2 read old on same-cycle write");
        rd('h0000, "R2 read new");

        // R1 aliasing
        rd('h8923, "R1 alias read");
        wr('hF800 | 'h055, 'h9E, "R1 alias write");
        rd('h0055, "R1 alias readback");
        wr('hFFF9, 'h42, "R1 alias window");
        rd(WIN + 1, "R1 alias seconds");

        // R3 control forcing
        wr(WIN, 'hFF, "R3 ctrl ff");
        rd(WIN, "R3 ctrl read");
        wr(WIN, 'h00, "R3 ctrl 00");
        rd(WIN, "R3 ctrl read");
        wr('h1FF8, 'h2B, "R3 ctrl alias");
        rd(WIN, "R3 ctrl read");

        // R5 carries through hours and weekday
        wr(WIN + 4, 'h07, "R9 wday 7");
        set_time('h03, 'h05, 'h14, 'h23, 'h59, 'h58, "R5 setup");
        tk(1, "R5 tick");
        rd(WIN + 1, "R5 sec 59");
        tk(1, "R5 tick wrap");
        rd_all("R5 carry to day");
        set_time('h03, 'h05, 'h14, 'h12, 'h58, 'h00, "R5 setup");
        for (int i = 0; i < 130; i++) step(0, (i % 7) == 0, WIN + 1 + (i % 3), 0, 1, "R5 run");
        rd_all("R5 after run");

        // R6 month lengths, leap years, year wrap
        set_time('h03, 'h02, 'h28, 'h23, 'h59, 'h59, "R6 setup feb");
        tk(1, "R6 feb common");
        rd_all("R6 feb common");
        set_time('h04, 'h02, 'h28, 'h23, 'h59, 'h59, "R6 setup leap");
        tk(1, "R6 feb leap");
        rd_all("R6 feb 29");
        wr(WIN + 1, 'h59, "R6 set sec");
        wr(WIN + 2, 'h59, "R6 set min");
        wr(WIN + 3, 'h23, "R6 set hour");
        tk(1, "R6 leap end");
        rd_all("R6 mar 01");
        set_time('h10, 'h04, 'h30, 'h23, 'h59, 'h59, "R6 setup apr");
        tk(1, "R6 apr end");
        rd_all("R6 may 01");
        set_time('h99, 'h12, 'h31, 'h23, 'h59, 'h59, "R6 setup dec");
        tk(1, "R6 year wrap");
        rd_all("R6 jan 00");
        set_time('h00, 'h02, 'h28, 'h23, 'h59, 'h59, "R6 setup y00");
        tk(1, "R6 y00 leap");
        rd(WIN + 5, "R6 y00 feb 29");

        // R7 stop flag: invalid low bits keep seconds, flag still taken
        set_time('h21, 'h07, 'h04, 'h10, 'h20, 'h30, "R7 setup");
        wr(WIN + 1, 'hFF, "R7 stop");
        tk(25, "R7 frozen");
        rd(WIN + 1, "R7 frozen sec");
        rd(WIN + 2, "R7 frozen min");
        wr(WIN + 1, 'h7F, "R7 resume");
        tk(3, "R7 resume");
        rd(WIN + 1, "R7 resumed sec");
        wr(WIN + 1, 'h85, "R7 stop with value");
        tk(4, "R7 frozen");
        rd(WIN + 1, "R7 read flag");
        wr(WIN + 1, 'h05, "R7 clear");

        // R8 / R10 range checks
        wr(WIN + 2, 'h60, "R8 min 60"); rd(WIN + 2, "R8 min kept");
        wr(WIN + 2, 'h1A, "R8 min digit"); rd(WIN + 2, "R8 min kept");
        wr(WIN + 2, 'h45, "R8 min ok"); rd(WIN + 2, "R8 min 45");
        wr(WIN + 1, 'h60, "R8 sec 60"); rd(WIN + 1, "R8 sec kept");
        wr(WIN + 3, 'h24, "R8 hour 24"); rd(WIN + 3, "R8 hour kept");
        wr(WIN + 3, 'h3A, "R8 hour digit"); rd(WIN + 3, "R8 hour kept");
        wr(WIN + 3, 'hC9, "R8 hour mask"); rd(WIN + 3, "R8 hour 09");
        wr(WIN + 5, 'h00, "R10 date 0"); rd(WIN + 5, "R10 date kept");
        wr(WIN + 5, 'h32, "R10 date 32"); rd(WIN + 5, "R10 date kept");
        wr(WIN + 5, 'h1C, "R10 date digit"); rd(WIN + 5, "R10 date kept");
        wr(WIN + 5, 'h27, "R10 date ok"); rd(WIN + 5, "R10 date 27");
        wr(WIN + 6, 'h00, "R10 mon 0"); rd(WIN + 6, "R10 mon kept");
        wr(WIN + 6, 'h13, "R10 mon 13"); rd(WIN + 6, "R10 mon kept");
        wr(WIN + 6, 'h0A, "R10 mon digit"); rd(WIN + 6, "R10 mon kept");
        wr(WIN + 6, 'h11, "R10 mon ok"); rd(WIN + 6, "R10 mon 11");
        wr(WIN + 7, 'hA0, "R10 year tens"); rd(WIN + 7, "R10 year kept");
        wr(WIN + 7, 'h9A, "R10 year ones"); rd(WIN + 7, "R10 year kept");
        wr(WIN + 7, 'h87, "R10 year ok"); rd(WIN + 7, "R10 year 87");

        // R9 weekday and century
        wr(WIN + 4, 'h45, "R9 wday cent"); rd(WIN + 4, "R9 read 45");
        wr(WIN + 4, 'hBF, "R9 mask"); rd(WIN + 4, "R9 read 07");
        wr(WIN + 4, 'h00, "R9 zero"); rd(WIN + 4, "R9 read 00");

        // R11 write and tick together
        set_time('h22, 'h03, 'h09, 'h08, 'h14, 'h59, "R11 setup");
        step(1, 0, WIN + 2, 'h33, 1, "R11 min write with carry");
        rd(WIN + 1, "R11 sec advanced");
        rd(WIN + 2, "R11 min written");
        step(1, 0, WIN + 1, 'h40, 1, "R11 sec write");
        rd(WIN + 1, "R11 sec written");
        step(1, 0, WIN + 6, 'h15, 1, "R11 bad mon write");
        rd(WIN + 1, "R11 sec advanced");
        rd(WIN + 6, "R11 mon kept");

        // R4 RAM survives reset, time restarts
        do_reset("R4 reset again");
        rd('h0123, "R4 ram kept");
        rd(WIN - 1, "R4 ram kept");
        rd_all("R4 time cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule